// File: doc/BRIEF.md
# Nibble-Serial Call/Return Program Counter Stack

This unit holds a 12-bit program counter and the stack pointer of a small 4-bit processor. It carries out the call, return, interrupt-entry and indexed-jump micro-operations. The counter has three nibble fields: a 4-bit page and an 8-bit step field. The step field is made of a high nibble and a low nibble. Return addresses go to an external nibble-wide stack memory one nibble at a time. Each micro-operation moves at most one nibble.

A microstep takes two clock cycles. The sequencer drives `step_phase` low for the fetch half and high for the write half, and holds the operation code steady across both. Program counter loads that come from immediates or registers take effect at the end of the fetch half. Memory writes are presented during the write half. Stack pointer updates and nibbles restored from memory take effect at the end of the write half. The memory port is registered. The read data is expected combinationally from the presented address.

Top module: `pcstk_top`

## Requirements
- R1: Call-start (op=3'd1) in the fetch half registers a write to address SP-1 (mod 256), held for the write half. With sel=0 the written nibble is the high nibble of step+1. With sel=1 it is the page. SP decrements by one at the end of the write half.
- R2: Call-end (op=3'd2) writes the low nibble of (old step)+1 to SP-1 during the write half, and SP then decrements. At the end of the fetch half the step field takes the 8-bit immediate.
- R3: At the end of its fetch half, call-end loads the page with next_page when sel=1 and with 0 when sel=0.
- R4: Return-end (op=3'd3) presents address SP+1 with no write during the write half. At the end of the write half it loads the read nibble into the high step nibble (sel=0) or the page (sel=1), and SP increments.
- R5: Interrupt-start (op=3'd4) writes the page to SP-1 during the write half and decrements SP. It raises ie_clear for exactly one cycle after the write half.
- R6: Indexed-jump-end (op=3'd5) loads a_nib into the low step nibble and next_page into the page at the end of the fetch half. The high step nibble is left unchanged and no memory write is issued.
- R7: With op=3'd0 and pc_inc=1 in a fetch half, the 8-bit step field increments modulo 256 and the page is unchanged. pc_inc has no effect while any other op is held.
- R8: SP wraps modulo 256: decrementing from 0x00 gives 0xFF, and incrementing from 0xFF gives 0x00.
- R9: mem_we is asserted only during write halves, never for two consecutive cycles, and never for return-end, indexed-jump-end or no-op.
- R10: After reset, SP is SP_RESET (default 0x00), the page and step fields are 0, and mem_we and ie_clear are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_phase | input | 1 | 0 = fetch half, 1 = write half of a microstep |
| op_code | input | 3 | Micro-operation: 0 none, 1 call-start, 2 call-end, 3 return-end, 4 interrupt-start, 5 indexed-jump-end |
| op_sel | input | 1 | Operation modifier bit (nibble or page source select) |
| pc_inc | input | 1 | Normal step increment request in a fetch half |
| imm8 | input | 8 | Call target for the step field |
| a_nib | input | 4 | A register nibble for indexed jump |
| next_page | input | 4 | Pending next-page value |
| mem_rdata | input | 4 | Stack memory read data |
| mem_addr | output | 8 | Stack memory address |
| mem_wdata | output | 4 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| pc_page | output | 4 | Page field of the program counter |
| pc_step | output | 8 | Step field of the program counter |
| sp | output | 8 | Stack pointer |
| ie_clear | output | 1 | One-cycle request to clear interrupt enable |

## Verification
The assertions take for granted that `step_phase` alternates strictly between fetch and write halves and that the operation code is held constant across the two halves of a microstep. They also assume only the listed codes appear. The one-write-per-step and write-half-only properties depend on this. The bench drives every operation through a single task that presents a fetch cycle and then a write cycle with identical controls. Between steps it inserts idle fetch halves with no operation and no increment, so the phase pattern never breaks.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_CALL_START = 3'd1,
    OP_CALL_END   = 3'd2,
    OP_RET_END    = 3'd3,
    OP_INT_START  = 3'd4,
    OP_JIDX_END   = 3'd5
  } op_e;

  function automatic logic is_push(input op_e op);
    return (op == OP_CALL_START) || (op == OP_CALL_END) || (op == OP_INT_START);
  endfunction

endpackage

// File: rtl/pcstk_sp.sv
module pcstk_sp
  import pcstk_pkg::*;
#(
  parameter int SP_W     = 8,
  parameter int SP_RESET = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_phase,
  input  op_e             op,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_dec,
  output logic [SP_W-1:0] sp_inc
);

  localparam logic [SP_W-1:0] SP_INIT = SP_W'(SP_RESET);
  localparam logic [SP_W-1:0] ONE     = SP_W'(1);

  assign sp_dec = sp_q - ONE;
  assign sp_inc = sp_q + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_INIT;
    end else if (step_phase) begin
      if (is_push(op))          sp_q <= sp_dec;
      else if (op == OP_RET_END) sp_q <= sp_inc;
    end
  end

  // R1 R2 R5: a push step lowers SP by one at the write-half edge
  p_push_dec_r1: assert property (@(posedge clk) disable iff (rst)
    (step_phase && is_push(op)) |=> (sp_q == $past(sp_q) - ONE));

  // R4: return-end raises SP by one
  p_ret_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (step_phase && op == OP_RET_END) |=> (sp_q == $past(sp_q) + ONE));

  // R8: decrement from zero wraps to all ones
  p_sp_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (step_phase && is_push(op) && sp_q == '0) |=> (sp_q == '1));

  // SP moves only at write-half edges
  p_sp_fetch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!step_phase) |=> $stable(sp_q));

endmodule

// File: rtl/pcstk_pc.sv
module pcstk_pc
  import pcstk_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_phase,
  input  op_e                    op,
  input  logic                   op_sel,
  input  logic                   pc_inc,
  input  logic [LANES*NIB_W-1:0] imm,
  input  logic [NIB_W-1:0]       a_nib,
  input  logic [NIB_W-1:0]       next_page,
  input  logic [NIB_W-1:0]       rd_nib,
  output logic [NIB_W-1:0]       page_q,
  output logic [LANES*NIB_W-1:0] step_q,
  output logic [LANES*NIB_W-1:0] step_p1
);

  localparam int STEP_W = LANES * NIB_W;

  logic [STEP_W-1:0] step_nxt;
  logic [NIB_W-1:0]  page_nxt;
  logic              fetch_h;
  logic              write_h;

  assign fetch_h = !step_phase;
  assign write_h = step_phase;
  assign step_p1 = step_q + STEP_W'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit IS_LO = (g == 0);
    localparam bit IS_HI = (g == LANES - 1);
    logic [NIB_W-1:0] lane_val;
    always_comb begin
      lane_val = step_q[g*NIB_W +: NIB_W];
      if (fetch_h) begin
        unique case (op)
          OP_CALL_END: lane_val = imm[g*NIB_W +: NIB_W];
          OP_JIDX_END: if (IS_LO) lane_val = a_nib;
          OP_NONE:     if (pc_inc) lane_val = step_p1[g*NIB_W +: NIB_W];
          default:     ;
        endcase
      end else if (write_h && op == OP_RET_END && !op_sel && IS_HI) begin
        lane_val = rd_nib;
      end
    end
    assign step_nxt[g*NIB_W +: NIB_W] = lane_val;
  end

  always_comb begin
    page_nxt = page_q;
    if (fetch_h) begin
      if (op == OP_CALL_END)      page_nxt = op_sel ? next_page : '0;
      else if (op == OP_JIDX_END) page_nxt = next_page;
    end else if (op == OP_RET_END && op_sel) begin
      page_nxt = rd_nib;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      page_q <= '0;
    end else begin
      step_q <= step_nxt;
      page_q <= page_nxt;
    end
  end

  // R7: increment never carries into the page
  p_inc_page_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_h && op == OP_NONE) |=> $stable(page_q));

  // R7: pending increment is ignored while a stack op is held
  p_op_blocks_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_h && (op == OP_CALL_START || op == OP_INT_START || op == OP_RET_END))
      |=> $stable(step_q));

  // R6: indexed jump leaves the upper step nibble alone
  p_jidx_hi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (fetch_h && op == OP_JIDX_END)
      |=> (step_q[STEP_W-1 -: NIB_W] == $past(step_q[STEP_W-1 -: NIB_W])));

  // R3: call-end with sel=0 lands on page zero
  p_callend_page0_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_h && op == OP_CALL_END && !op_sel) |=> (page_q == '0));

endmodule

// File: rtl/pcstk_mem_if.sv
module pcstk_mem_if
  import pcstk_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int SP_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_phase,
  input  op_e                op,
  input  logic               op_sel,
  input  logic [SP_W-1:0]    sp_dec,
  input  logic [SP_W-1:0]    sp_inc,
  input  logic [NIB_W-1:0]   page,
  input  logic [2*NIB_W-1:0] step_p1,
  output logic [SP_W-1:0]    mem_addr,
  output logic [NIB_W-1:0]   mem_wdata,
  output logic               mem_we
);

  logic [NIB_W-1:0] push_nib;

  always_comb begin
    unique case (op)
      OP_CALL_START: push_nib = op_sel ? page : step_p1[2*NIB_W-1 -: NIB_W];
      OP_CALL_END:   push_nib = step_p1[NIB_W-1:0];
      default:       push_nib = page;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else if (!step_phase) begin
      if (is_push(op)) begin
        mem_we    <= 1'b1;
        mem_addr  <= sp_dec;
        mem_wdata <= push_nib;
      end else begin
        mem_we <= 1'b0;
        if (op == OP_RET_END) mem_addr <= sp_inc;
      end
    end else begin
      mem_we <= 1'b0;
    end
  end

  // R9: writes appear only in the write half
  p_we_write_half_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> step_phase);

  // R9: one write per microstep at most
  p_single_write_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R4: return-end never writes
  p_ret_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!step_phase && op == OP_RET_END) |=> !mem_we);

endmodule

// File: rtl/pcstk_top.sv
module pcstk_top
  import pcstk_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int SP_W     = 8,
  parameter int SP_RESET = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_phase,
  input  logic [2:0]         op_code,
  input  logic               op_sel,
  input  logic               pc_inc,
  input  logic [2*NIB_W-1:0] imm8,
  input  logic [NIB_W-1:0]   a_nib,
  input  logic [NIB_W-1:0]   next_page,
  input  logic [NIB_W-1:0]   mem_rdata,
  output logic [SP_W-1:0]    mem_addr,
  output logic [NIB_W-1:0]   mem_wdata,
  output logic               mem_we,
  output logic [NIB_W-1:0]   pc_page,
  output logic [2*NIB_W-1:0] pc_step,
  output logic [SP_W-1:0]    sp,
  output logic               ie_clear
);

  op_e                op;
  logic [SP_W-1:0]    sp_dec;
  logic [SP_W-1:0]    sp_inc;
  logic [2*NIB_W-1:0] step_p1;

  assign op = op_e'(op_code);

  pcstk_sp #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_sp (
    .clk        (clk),
    .rst        (rst),
    .step_phase (step_phase),
    .op         (op),
    .sp_q       (sp),
    .sp_dec     (sp_dec),
    .sp_inc     (sp_inc)
  );

  pcstk_pc #(.NIB_W(NIB_W), .LANES(2)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .step_phase (step_phase),
    .op         (op),
    .op_sel     (op_sel),
    .pc_inc     (pc_inc),
    .imm        (imm8),
    .a_nib      (a_nib),
    .next_page  (next_page),
    .rd_nib     (mem_rdata),
    .page_q     (pc_page),
    .step_q     (pc_step),
    .step_p1    (step_p1)
  );

  pcstk_mem_if #(.NIB_W(NIB_W), .SP_W(SP_W)) u_mem (
    .clk        (clk),
    .rst        (rst),
    .step_phase (step_phase),
    .op         (op),
    .op_sel     (op_sel),
    .sp_dec     (sp_dec),
    .sp_inc     (sp_inc),
    .page       (pc_page),
    .step_p1    (step_p1),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we)
  );

  always_ff @(posedge clk) begin
    if (rst) ie_clear <= 1'b0;
    else     ie_clear <= step_phase && (op == OP_INT_START);
  end

  // R5: interrupt-enable clear is a single-cycle pulse
  p_ieclr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ie_clear |=> !ie_clear);

  // R5: pulse follows an interrupt-start write half
  p_ieclr_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (step_phase && op == OP_INT_START) |=> ie_clear);

endmodule

// File: tb/tb_pcstk_top.sv
module tb_pcstk_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       step_phase;
  logic [2:0] op_code;
  logic       op_sel;
  logic       pc_inc;
  logic [7:0] imm8;
  logic [3:0] a_nib;
  logic [3:0] next_page;
  logic [3:0] mem_rdata;
  logic [7:0] mem_addr;
  logic [3:0] mem_wdata;
  logic       mem_we;
  logic [3:0] pc_page;
  logic [7:0] pc_step;
  logic [7:0] sp;
  logic       ie_clear;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // mid-step snapshot taken during the write half
  logic       m_we;
  logic [7:0] m_addr;
  logic [3:0] m_data;
  logic [7:0] m_step;
  logic [3:0] m_page;

  logic [3:0] smem [256];

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (mem_we) smem[mem_addr] <= mem_wdata;
  assign mem_rdata = smem[mem_addr];

  pcstk_top dut (
    .clk(clk), .rst(rst), .step_phase(step_phase), .op_code(op_code),
    .op_sel(op_sel), .pc_inc(pc_inc), .imm8(imm8), .a_nib(a_nib),
    .next_page(next_page), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_page(pc_page),
    .pc_step(pc_step), .sp(sp), .ie_clear(ie_clear)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one microstep: fetch half then write half, then returns in the next idle fetch half
  task automatic run_step(input logic [2:0] op, input logic sel, input logic inc,
                          input logic [7:0] im, input logic [3:0] an, input logic [3:0] np);
    @(negedge clk);
    step_phase = 1'b0; op_code = op; op_sel = sel; pc_inc = inc;
    imm8 = im; a_nib = an; next_page = np;
    @(negedge clk);
    step_phase = 1'b1;
    m_we = mem_we; m_addr = mem_addr; m_data = mem_wdata;
    m_step = pc_step; m_page = pc_page;
    @(negedge clk);
    step_phase = 1'b0; op_code = 3'd0; op_sel = 1'b0; pc_inc = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 sp", sp, 8'h00);
    chk("R10 page", pc_page, 0);
    chk("R10 step", pc_step, 8'h00);
    chk("R10 we", mem_we, 0);
    chk("R10 ie_clear", ie_clear, 0);
  endtask

  task automatic t_call_end();
    run_step(3'd2, 1'b1, 1'b0, 8'hA7, 4'h0, 4'h5);
    chk("R2 we", m_we, 1);
    chk("R8 addr wrap", m_addr, 8'hFF);
    chk("R2 low nibble", m_data, 4'h1);
    chk("R2 step imm", m_step, 8'hA7);
    chk("R3 page npp", m_page, 4'h5);
    chk("R8 sp wrap", sp, 8'hFF);
    run_step(3'd2, 1'b0, 1'b0, 8'hFF, 4'h0, 4'h9);
    chk("R2 addr", m_addr, 8'hFE);
    chk("R2 low of A8", m_data, 4'h8);
    chk("R3 page zero", m_page, 4'h0);
    chk("R2 sp dec", sp, 8'hFE);
  endtask

  task automatic t_jidx_and_inc();
    run_step(3'd5, 1'b0, 1'b1, 8'h00, 4'h3, 4'h6);
    chk("R6 step", m_step, 8'hF3);
    chk("R6 page", m_page, 4'h6);
    chk("R6 no write", m_we, 0);
    chk("R6 sp hold", sp, 8'hFE);
    run_step(3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0);
    chk("R7 inc", m_step, 8'hF4);
    chk("R7 page kept", m_page, 4'h6);
    chk("R9 none no write", m_we, 0);
  endtask

  task automatic t_inc_wrap();
    run_step(3'd2, 1'b1, 1'b0, 8'hFF, 4'h0, 4'h2);
    run_step(3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0);
    chk("R7 step wrap", pc_step, 8'h00);
    chk("R7 no carry page", pc_page, 4'h2);
    run_step(3'd5, 1'b0, 1'b0, 8'h00, 4'h4, 4'h6);
    run_step(3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0);
    run_step(3'd0, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0);
    chk("R7 restored", pc_step, 8'h06);
  endtask

  task automatic t_call_ret();
    // prepare step=F4 page=6, sp=FD after the call-end above
    run_step(3'd2, 1'b1, 1'b0, 8'hF4, 4'h0, 4'h6);
    chk("R2 sp", sp, 8'hFC);
    run_step(3'd1, 1'b1, 1'b1, 8'h00, 4'h0, 4'h0);
    chk("R1 addr", m_addr, 8'hFB);
    chk("R1 page nibble", m_data, 4'h6);
    chk("R7 ignored", m_step, 8'hF4);
    chk("R1 sp", sp, 8'hFB);
    run_step(3'd1, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0);
    chk("R1 hi nibble", m_data, 4'hF);
    chk("R1 addr2", m_addr, 8'hFA);
    run_step(3'd2, 1'b1, 1'b0, 8'h2C, 4'h0, 4'h3);
    chk("R2 low F5", m_data, 4'h5);
    chk("R2 target", pc_step, 8'h2C);
    chk("R3 page", pc_page, 4'h3);
    chk("R2 sp3", sp, 8'hF9);
    run_step(3'd3, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0);
    chk("R4 no write", m_we, 0);
    chk("R4 addr", m_addr, 8'hFA);
    chk("R4 step hi", pc_step, 8'hFC);
    chk("R4 sp", sp, 8'hFA);
    run_step(3'd3, 1'b1, 1'b0, 8'h00, 4'h0, 4'h0);
    chk("R4 page", pc_page, 4'h6);
    chk("R4 sp2", sp, 8'hFB);
  endtask

  task automatic t_int();
    run_step(3'd4, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0);
    chk("R5 we", m_we, 1);
    chk("R5 addr", m_addr, 8'hFA);
    chk("R5 data", m_data, 4'h6);
    chk("R5 sp", sp, 8'hFA);
    chk("R5 ie_clear high", ie_clear, 1);
    @(negedge clk);
    chk("R5 ie_clear pulse", ie_clear, 0);
  endtask

  task automatic t_ret_wrap();
    smem[0] = 4'hB;
    for (int i = 0; i < 6; i++) run_step(3'd3, 1'b1, 1'b0, 8'h00, 4'h0, 4'h0);
    chk("R8 sp inc wrap", sp, 8'h00);
    chk("R4 page from 00", pc_page, 4'hB);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = 4'h0;
    rst = 1'b1; step_phase = 1'b0; op_code = 3'd0; op_sel = 1'b0; pc_inc = 1'b0;
    imm8 = 8'h00; a_nib = 4'h0; next_page = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_call_end();
    t_jidx_and_inc();
    t_inc_wrap();
    t_call_ret();
    t_int();
    t_ret_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule